// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block walks a register list for a multi-word block transfer. A one-cycle start pulse loads a bitmask of registers, a base address, a two-bit addressing mode and a writeback enable. Over the following cycles the block issues one beat per set bit in the mask. Each beat carries a valid strobe, the index of the register to move and the word address for that register. Memory accesses and register-file updates are done by the surrounding pipeline, which consumes these beats.

When a start is accepted, the block counts the set bits in the list. From that count it works out the lowest address of the block, the last address and the new base value. Because of this, every mode issues registers in ascending index order at ascending word addresses. Only the placement of the window relative to the base changes with the mode. The three computed addresses stay on dedicated outputs until the next accepted start. A done pulse marks the end of each transfer. A writeback strobe comes with that done pulse only when writeback was requested.

Top module: `lsm_seq`

## Requirements
- R1: After an accepted start, `validO` is high for exactly as many consecutive cycles as there are set bits in `regListI`, beginning in the cycle after the start.
- R2: Beats carry register indices in strictly ascending order, one set bit of the list per beat. Each beat's address is 4 above the previous beat's address.
- R3: Mode 1 (increment-after): the first address is base, the last is base+4n−4, and the writeback value is base+4n.
- R4: Mode 2 (decrement-before): the first address is base−4n, the last is base−4, and the writeback value is base−4n.
- R5: Mode 3 (increment-before): the first address is base+4, the last is base+4n, and the writeback value is base+4n.
- R6: Mode 0 (decrement-after): the first address is base−4n+4, the last is base, and the writeback value is base−4n.
- R7: `wbWriteO` is high only in the cycle of `doneO`, and only when `wbEnI` was high at the accepted start.
- R8: An all-zero list produces no beats, and `doneO` pulses for one cycle in the cycle after the start.
- R9: `doneO` is high in the same cycle as the final beat. That beat's address equals `endAddrO`.
- R10: A start that arrives while a transfer is in progress is ignored. The running sequence, and the reported addresses, stay unchanged.
- R11: After reset, `validO`, `doneO`, `busyO` and `wbWriteO` are low.
- R12: All address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startI | input | 1 | Start pulse; accepted only when idle |
| regListI | input | NUM_REGS | Register bitmask |
| baseI | input | ADDR_W | Base address |
| modeI | input | 2 | Addressing mode: 0 DA, 1 IA, 2 DB, 3 IB |
| wbEnI | input | 1 | Writeback request |
| validO | output | 1 | Beat valid |
| regIdxO | output | IDX_W | Register index of the beat |
| addrO | output | ADDR_W | Word address of the beat |
| startAddrO | output | ADDR_W | First address of the transfer |
| endAddrO | output | ADDR_W | Last address of the transfer |
| wbValueO | output | ADDR_W | New base value |
| wbWriteO | output | 1 | Base writeback strobe |
| busyO | output | 1 | Transfer in progress |
| doneO | output | 1 | Transfer complete pulse |

## Verification
The bench uses the default build: 16 registers, 32-bit addresses and 4-byte words. With these settings a full 16-bit list can be sequenced, and a base near zero wraps in decrement modes. The full list reaches the largest popcount and the longest run, so the window offsets reach their extreme of 64 bytes. Single-bit lists at each end of the mask, and the empty list, cover the boundaries of the lowest-set-bit search and of the done timing.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    MODE_DA = 2'd0,
    MODE_IA = 2'd1,
    MODE_DB = 2'd2,
    MODE_IB = 2'd3
  } xferMode_t;

  typedef struct packed {
    logic load;
    logic step;
  } seqStrobes_t;
endpackage

// File: rtl/lsm_seq_ctrl.sv
module lsm_seq_ctrl
  import lsm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startI,
  input  logic        listZeroI,
  input  logic        remLastI,
  output seqStrobes_t strobeO,
  output logic        validO,
  output logic        busyO,
  output logic        doneO
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_t;
  state_t stateQ, stateD;
  logic emptyDoneQ;
  logic accept;

  assign accept = startI && (stateQ == ST_IDLE);

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (accept && !listZeroI) stateD = ST_BUSY;
      ST_BUSY: if (remLastI) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      emptyDoneQ <= 1'b0;
    end else begin
      stateQ     <= stateD;
      emptyDoneQ <= accept && listZeroI;
    end
  end

  assign strobeO.load = accept;
  assign strobeO.step = (stateQ == ST_BUSY);
  assign validO       = (stateQ == ST_BUSY);
  assign busyO        = (stateQ == ST_BUSY);
  assign doneO        = ((stateQ == ST_BUSY) && remLastI) || emptyDoneQ;

  // R8: the empty-list done never overlaps a running transfer
  p_empty_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    emptyDoneQ |-> !validO);
  // R10: a start while busy leaves the sequencer busy until its final beat
  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (validO && !remLastI && startI) |=> validO);
endmodule

// File: rtl/lsm_seq_dpath.sv
module lsm_seq_dpath
  import lsm_pkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(NUM_REGS),
  localparam int CNT_W     = $clog2(NUM_REGS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobes_t         strobeI,
  input  logic [NUM_REGS-1:0] regListI,
  input  logic [ADDR_W-1:0]   baseI,
  input  logic [1:0]          modeI,
  input  logic                wbEnI,
  output logic                listZeroO,
  output logic                remLastO,
  output logic [IDX_W-1:0]    regIdxO,
  output logic [ADDR_W-1:0]   addrO,
  output logic [ADDR_W-1:0]   startAddrO,
  output logic [ADDR_W-1:0]   endAddrO,
  output logic [ADDR_W-1:0]   wbValueO,
  output logic                wbEnO
);
  localparam logic [ADDR_W-1:0] WORD = ADDR_W'(WORD_BYTES);

  logic [NUM_REGS-1:0] remQ;
  logic [ADDR_W-1:0]   addrQ, startQ, endQ, wbQ;
  logic                wbEnQ;
  logic [CNT_W-1:0]    popCnt;
  logic [ADDR_W-1:0]   span, startCalc, wbCalc;

  always_comb begin
    popCnt = '0;
    for (int i = 0; i < NUM_REGS; i++) popCnt = popCnt + CNT_W'(regListI[i]);
  end

  assign span = ADDR_W'(popCnt) * WORD;

  always_comb begin
    case (xferMode_t'(modeI))
      MODE_IA: begin startCalc = baseI;               wbCalc = baseI + span; end
      MODE_IB: begin startCalc = baseI + WORD;        wbCalc = baseI + span; end
      MODE_DB: begin startCalc = baseI - span;        wbCalc = baseI - span; end
      default: begin startCalc = baseI - span + WORD; wbCalc = baseI - span; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remQ   <= '0;
      addrQ  <= '0;
      startQ <= '0;
      endQ   <= '0;
      wbQ    <= '0;
      wbEnQ  <= 1'b0;
    end else if (strobeI.load) begin
      remQ   <= regListI;
      addrQ  <= startCalc;
      startQ <= startCalc;
      endQ   <= startCalc + span - WORD;
      wbQ    <= wbCalc;
      wbEnQ  <= wbEnI;
    end else if (strobeI.step) begin
      remQ   <= remQ & (remQ - 1'b1);
      addrQ  <= addrQ + WORD;
    end
  end

  always_comb begin
    regIdxO = '0;
    for (int i = NUM_REGS - 1; i >= 0; i--)
      if (remQ[i]) regIdxO = IDX_W'(i);
  end

  assign listZeroO  = (regListI == '0);
  assign remLastO   = ((remQ & (remQ - 1'b1)) == '0);
  assign addrO      = addrQ;
  assign startAddrO = startQ;
  assign endAddrO   = endQ;
  assign wbValueO   = wbQ;
  assign wbEnO      = wbEnQ;

  // R10: reported addresses hold while a transfer steps
  p_hold_reports_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobeI.step && !strobeI.load) |=> $stable(startQ) && $stable(endQ) && $stable(wbQ));
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
  import lsm_pkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startI,
  input  logic [NUM_REGS-1:0] regListI,
  input  logic [ADDR_W-1:0]   baseI,
  input  logic [1:0]          modeI,
  input  logic                wbEnI,
  output logic                validO,
  output logic [IDX_W-1:0]    regIdxO,
  output logic [ADDR_W-1:0]   addrO,
  output logic [ADDR_W-1:0]   startAddrO,
  output logic [ADDR_W-1:0]   endAddrO,
  output logic [ADDR_W-1:0]   wbValueO,
  output logic                wbWriteO,
  output logic                busyO,
  output logic                doneO
);
  seqStrobes_t strobes;
  logic listZero, remLast, wbEn;

  lsm_seq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .startI(startI), .listZeroI(listZero),
    .remLastI(remLast), .strobeO(strobes), .validO(validO),
    .busyO(busyO), .doneO(doneO)
  );

  lsm_seq_dpath #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strobeI(strobes), .regListI(regListI),
    .baseI(baseI), .modeI(modeI), .wbEnI(wbEnI), .listZeroO(listZero),
    .remLastO(remLast), .regIdxO(regIdxO), .addrO(addrO),
    .startAddrO(startAddrO), .endAddrO(endAddrO), .wbValueO(wbValueO),
    .wbEnO(wbEn)
  );

  assign wbWriteO = doneO && wbEn;

  // R2: consecutive beats climb by one word and by register index
  p_ascending_r2: assert property (@(posedge clk) disable iff (!rstN)
    (validO && !doneO) |=> validO && (addrO == $past(addrO) + ADDR_W'(WORD_BYTES))
                           && (regIdxO > $past(regIdxO)));
  // R9: final beat lands on the precomputed end address
  p_last_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (validO && doneO) |-> (addrO == endAddrO));
  // R7: writeback strobe only with done
  p_wb_with_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    wbWriteO |-> doneO);
  // R1: first beat sits at the start address
  p_first_beat_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validO) |-> (addrO == startAddrO));
endmodule

// File: tb/test_lsm_seq.sv
module test_lsm_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startI = 1'b0;
  logic [15:0] regListI = '0;
  logic [31:0] baseI = '0;
  logic [1:0]  modeI = '0;
  logic        wbEnI = 1'b0;
  logic validO, wbWriteO, busyO, doneO;
  logic [3:0]  regIdxO;
  logic [31:0] addrO, startAddrO, endAddrO, wbValueO;

  int nTests = 0;
  int nFails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  lsm_seq i_lsm_seq (
    .clk(clk), .rstN(rstN), .startI(startI), .regListI(regListI), .baseI(baseI),
    .modeI(modeI), .wbEnI(wbEnI), .validO(validO), .regIdxO(regIdxO), .addrO(addrO),
    .startAddrO(startAddrO), .endAddrO(endAddrO), .wbValueO(wbValueO),
    .wbWriteO(wbWriteO), .busyO(busyO), .doneO(doneO)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nTests++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
        $finish;
      end
    end
  end

  // Behavioural reference: one transfer, optional stray start at beat injectAt
  task automatic runXfer(string req, logic [15:0] list, logic [31:0] base,
                         logic [1:0] mode, logic wb, int injectAt);
    int idxQ[$];
    logic [31:0] span, firstA, wbv;
    int n;
    n = 0;
    for (int i = 0; i < 16; i++) if (list[i]) begin idxQ.push_back(i); n++; end
    span = 32'(n * 4);
    case (mode)
      2'd1: begin firstA = base;            wbv = base + span; end
      2'd3: begin firstA = base + 32'd4;    wbv = base + span; end
      2'd2: begin firstA = base - span;     wbv = base - span; end
      default: begin firstA = base - span + 32'd4; wbv = base - span; end
    endcase
    @(negedge clk);
    startI = 1'b1; regListI = list; baseI = base; modeI = mode; wbEnI = wb;
    @(negedge clk);
    startI = 1'b0; regListI = 16'h5A5A; baseI = 32'hDEAD0000; modeI = ~mode; wbEnI = ~wb;
    if (n == 0) begin
      check({req, " R8 valid"}, 32'(validO), 0);
      check({req, " R8 done"}, 32'(doneO), 1);
      check({req, " R7 wb"}, 32'(wbWriteO), 32'(wb));
    end
    for (int k = 0; k < n; k++) begin
      check({req, " R1 valid"}, 32'(validO), 1);
      check({req, " R2 idx"}, 32'(regIdxO), 32'(idxQ[k]));
      check({req, " addr"}, addrO, firstA + 32'(4 * k));
      check({req, " R9 done"}, 32'(doneO), 32'(k == n - 1));
      check({req, " R7 wb"}, 32'(wbWriteO), 32'(wb && (k == n - 1)));
      check({req, " start"}, startAddrO, firstA);
      check({req, " end"}, endAddrO, firstA + span - 32'd4);
      check({req, " wbval"}, wbValueO, wbv);
      startI = (k == injectAt);
      @(negedge clk);
      startI = 1'b0;
    end
    if (n == 0) @(negedge clk);
    check({req, " idle valid"}, 32'(validO), 0);
    check({req, " idle done"}, 32'(doneO), 0);
    check({req, " idle wb"}, 32'(wbWriteO), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 valid", 32'(validO), 0);
    check("R11 done", 32'(doneO), 0);
    check("R11 busy", 32'(busyO), 0);
    check("R11 wb", 32'(wbWriteO), 0);
    rstN = 1'b1;
    runXfer("R3 IA", 16'h00F1, 32'h0000_1000, 2'd1, 1'b1, -1);
    runXfer("R4 DB", 16'h8005, 32'h0000_2000, 2'd2, 1'b0, -1);
    runXfer("R5 IB", 16'h0C30, 32'h0000_3000, 2'd3, 1'b1, -1);
    runXfer("R6 DA", 16'h1248, 32'h0000_4000, 2'd0, 1'b1, -1);
    runXfer("R1 full", 16'hFFFF, 32'h0000_8000, 2'd1, 1'b1, -1);
    runXfer("R6 fullDA", 16'hFFFF, 32'h0000_8000, 2'd0, 1'b0, -1);
    runXfer("R2 top bit", 16'h8000, 32'h0000_0100, 2'd2, 1'b1, -1);
    runXfer("R2 low bit", 16'h0001, 32'h0000_0100, 2'd3, 1'b0, -1);
    runXfer("R8 empty", 16'h0000, 32'h0000_0500, 2'd1, 1'b1, -1);
    runXfer("R10 stray0", 16'h0330, 32'h0000_6000, 2'd1, 1'b1, 0);
    runXfer("R10 strayLast", 16'h0003, 32'h0000_6100, 2'd2, 1'b0, 1);
    runXfer("R12 wrap", 16'h0007, 32'h0000_0008, 2'd2, 1'b1, -1);
    runXfer("R12 wrapIB", 16'h0003, 32'hFFFF_FFFC, 2'd3, 1'b1, -1);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule